// File: doc/BRIEF.md
# Shared Interrupt Sense and Mask

This block takes a parameterized number of external interrupt lines (a multiple of 8, at most 256). It turns each line into a pending bit according to that line's own sense settings. Every line has three control bits:

- **polarity**: active high or rising when set, active low or falling when clear.
- **trigger**: edge when set, level when clear.
- **dual-edge**: catch both edges when set; polarity is then ignored.

Raw lines pass through a two-flop synchronizer first. In level mode the pending bit follows the polarity-corrected line. In edge mode a latch captures the chosen edge and holds it until software clears it.

Software reaches the block through a simple word-wide register port with separate write and read strobes. Enables are changed by writing a single interrupt index to a set-enable or clear-enable register. A third index register either clears a captured edge, which acknowledges it, or forces the edge latch on when bit 31 is set, so software can raise an interrupt to another processor. Pending, enable and sense settings can be read as packed 32-bit words. A read-only identity word reports the line count and the processor count. A single registered request output shows that at least one pending line is enabled. Routing to processors is done elsewhere.

Top module: `shirq_ctrl`

## Requirements
- R1: Reading address 0x00 returns the identity word: bits [23:16] = NUM_IRQ/8 − 1, bits [7:0] = NUM_CPU − 1, all other bits 0.
- R2: After reset every line is active high (polarity bits 1), level triggered (trigger bits 0), single edge (dual bits 0) and disabled (enable bits 0), and irq_req is 0.
- R3: With trigger 0, the pending bit of line k equals irq_in[k] when its polarity is 1 and the inverse of irq_in[k] when its polarity is 0. The bit settles within four clocks of the input change.
- R4: With trigger 1 and dual 0, the pending bit is set by a rising edge (polarity 1) or a falling edge (polarity 0). It stays set after the line returns to its former level.
- R5: With trigger 1 and dual 1, either edge sets the pending bit, whatever the polarity.
- R6: Writing index k (bits [7:0]) with bit 31 clear to address 0x03 clears the captured edge of line k only. Other captured edges are unaffected.
- R7: Writing index k with bit 31 set to address 0x03 sets the edge latch of line k, so an edge-mode line reads as pending.
- R8: Writing index k to 0x01 sets enable bit k, and writing it to 0x02 clears that bit. Indices at or above NUM_IRQ change nothing. Enable bit k is readable at address 0x50 + k/32, bit k%32.
- R9: irq_req is 1 exactly when some line is both pending and enabled. It is registered one clock after the pending and enable state.
- R10: While a line is in level mode its edge latch is held clear, so switching it to edge mode shows no stale edge from level-mode activity or from a raise written then.
- R11: Polarity, trigger and dual settings are read and written as words at 0x10 + w, 0x20 + w and 0x30 + w. Pending is readable at 0x40 + w. Bits for lines at or above NUM_IRQ, and words past the last one, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IRQ | Raw asynchronous interrupt lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 32 | Read data, valid the clock after rd_en |
| irq_req | output | 1 | At least one pending line is enabled |

## Verification
The bench sweeps every line of a 40-line build through all six sense settings. For each setting it drives the sequence low, high, low on that line and checks the pending bit at each step. The expected value comes from an arithmetic model of level versus latched behaviour. This separates active-high from active-low level mode, and rising from falling capture. It also shows that dual-edge capture ignores polarity and that an edge stays captured after the line returns to its former level. Directed cases cover the remaining corners:

- clearing one captured edge while another is held;
- software raises;
- discarding level-mode activity on a switch to edge mode;
- enable indices past the last line;
- the partially filled second word.

// File: rtl/shirq_pkg.sv
package shirq_pkg;

  // Upper address nibble selects a register region.
  typedef enum logic [3:0] {
    RG_CTRL = 4'h0,
    RG_POL  = 4'h1,
    RG_TRIG = 4'h2,
    RG_DUAL = 4'h3,
    RG_PEND = 4'h4,
    RG_MASK = 4'h5
  } region_e;

  // Lower nibble offsets inside the control region.
  localparam logic [3:0] OFF_IDENT = 4'h0;
  localparam logic [3:0] OFF_MSET  = 4'h1;
  localparam logic [3:0] OFF_MCLR  = 4'h2;
  localparam logic [3:0] OFF_EDGE  = 4'h3;

  localparam int RAISE_BIT   = 31;
  localparam int ID_CNT_LSB  = 16;
  localparam int ID_CPU_LSB  = 0;
  localparam int WORD_BITS   = 32;

endpackage

// File: rtl/shirq_sync.sv
module shirq_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/shirq_regs.sv
module shirq_regs
  import shirq_pkg::*;
#(
  parameter int NUM_IRQ = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [31:0]        wr_data,
  output logic [NUM_IRQ-1:0] pol,
  output logic [NUM_IRQ-1:0] trig,
  output logic [NUM_IRQ-1:0] dual,
  output logic [NUM_IRQ-1:0] mask,
  output logic [NUM_IRQ-1:0] edge_clr,
  output logic [NUM_IRQ-1:0] edge_set
);
  localparam int NW   = (NUM_IRQ + WORD_BITS - 1) / WORD_BITS;
  localparam int PADW = NW * WORD_BITS;
  localparam logic [NUM_IRQ-1:0] ONE = NUM_IRQ'(1);

  logic [3:0]         region;
  logic [3:0]         off;
  logic [7:0]         idx;
  logic               idx_ok;
  logic [NUM_IRQ-1:0] onehot;
  logic               ctrl_wr, mset, mclr, edge_wr;
  logic [NUM_IRQ-1:0] pol_n, trig_n, dual_n, mask_n;

  // Replace one 32-bit word of a bitmap; words past the end are dropped.
  function automatic logic [NUM_IRQ-1:0] put_word(input logic [NUM_IRQ-1:0] cur,
                                                  input logic [3:0] w,
                                                  input logic [31:0] d);
    logic [PADW-1:0] p;
    p = PADW'(cur);
    if (int'(w) < NW) p[int'(w)*WORD_BITS +: WORD_BITS] = d;
    return p[NUM_IRQ-1:0];
  endfunction

  assign region  = wr_addr[7:4];
  assign off     = wr_addr[3:0];
  assign idx     = wr_data[7:0];
  assign idx_ok  = ({1'b0, idx} < 9'(NUM_IRQ));
  assign onehot  = idx_ok ? (ONE << idx) : '0;
  assign ctrl_wr = wr_en && (region == RG_CTRL);
  assign mset    = ctrl_wr && (off == OFF_MSET);
  assign mclr    = ctrl_wr && (off == OFF_MCLR);
  assign edge_wr = ctrl_wr && (off == OFF_EDGE);

  assign edge_clr = (edge_wr && !wr_data[RAISE_BIT]) ? onehot : '0;
  assign edge_set = (edge_wr &&  wr_data[RAISE_BIT]) ? onehot : '0;

  always_comb begin
    pol_n  = pol;
    trig_n = trig;
    dual_n = dual;
    mask_n = mask;
    if (wr_en && region == RG_POL)  pol_n  = put_word(pol,  off, wr_data);
    if (wr_en && region == RG_TRIG) trig_n = put_word(trig, off, wr_data);
    if (wr_en && region == RG_DUAL) dual_n = put_word(dual, off, wr_data);
    if (mset) mask_n = mask | onehot;
    if (mclr) mask_n = mask & ~onehot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pol  <= '1;
      trig <= '0;
      dual <= '0;
      mask <= '0;
    end else begin
      pol  <= pol_n;
      trig <= trig_n;
      dual <= dual_n;
      mask <= mask_n;
    end
  end

  // R2
  mask_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask == '0 && trig == '0 && pol == '1));

  // R8
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 8'h01 && {1'b0, wr_data[7:0]} < 9'(NUM_IRQ))
      |=> |(mask & (ONE << $past(wr_data[7:0]))));

  // R8
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 8'h02 && {1'b0, wr_data[7:0]} < 9'(NUM_IRQ))
      |=> !(|(mask & (ONE << $past(wr_data[7:0])))));
endmodule

// File: rtl/shirq_sense.sv
module shirq_sense #(
  parameter int NUM_IRQ = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] line,
  input  logic [NUM_IRQ-1:0] pol,
  input  logic [NUM_IRQ-1:0] trig,
  input  logic [NUM_IRQ-1:0] dual,
  input  logic [NUM_IRQ-1:0] edge_clr,
  input  logic [NUM_IRQ-1:0] edge_set,
  output logic [NUM_IRQ-1:0] pend
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic prev_q, lvl_q, edge_q;
    logic rise, fall, hit;

    assign rise = line[i] & ~prev_q;
    assign fall = ~line[i] & prev_q;
    assign hit  = dual[i] ? (rise | fall) : (pol[i] ? rise : fall);

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q <= 1'b0;
        lvl_q  <= 1'b0;
        edge_q <= 1'b0;
      end else begin
        prev_q <= line[i];
        lvl_q  <= pol[i] ? line[i] : ~line[i];
        if (!trig[i])                 edge_q <= 1'b0;
        else if (hit || edge_set[i])  edge_q <= 1'b1;
        else if (edge_clr[i])         edge_q <= 1'b0;
      end
    end

    assign pend[i] = trig[i] ? edge_q : lvl_q;

    // R6
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (trig[i] && edge_q && !edge_clr[i]) |=> edge_q);

    // R7
    edge_raise_chk: assert property (@(posedge clk) disable iff (rst)
      (trig[i] && edge_set[i]) |=> edge_q);

    // R10
    level_latch_chk: assert property (@(posedge clk) disable iff (rst)
      !trig[i] |=> !edge_q);
  end
endmodule

// File: rtl/shirq_ctrl.sv
module shirq_ctrl
  import shirq_pkg::*;
#(
  parameter int NUM_IRQ = 40,
  parameter int NUM_CPU = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [31:0]        wr_data,
  input  logic               rd_en,
  input  logic [7:0]         rd_addr,
  output logic [31:0]        rd_data,
  output logic               irq_req
);
  // NUM_IRQ must be a multiple of 8 in 8..256; NUM_CPU in 1..256.
  localparam int NW   = (NUM_IRQ + WORD_BITS - 1) / WORD_BITS;
  localparam int PADW = NW * WORD_BITS;
  localparam logic [31:0] IDENT =
      (32'(NUM_IRQ / 8 - 1) << ID_CNT_LSB) | (32'(NUM_CPU - 1) << ID_CPU_LSB);

  logic [NUM_IRQ-1:0] line_s, pol, trig, dual, mask, edge_clr, edge_set, pend;
  logic [31:0]        rd_n;

  shirq_sync #(.WIDTH(NUM_IRQ)) u_sync (
    .clk(clk), .rst(rst), .d(irq_in), .q(line_s)
  );

  shirq_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pol(pol), .trig(trig), .dual(dual), .mask(mask),
    .edge_clr(edge_clr), .edge_set(edge_set)
  );

  shirq_sense #(.NUM_IRQ(NUM_IRQ)) u_sense (
    .clk(clk), .rst(rst), .line(line_s), .pol(pol), .trig(trig), .dual(dual),
    .edge_clr(edge_clr), .edge_set(edge_set), .pend(pend)
  );

  function automatic logic [31:0] get_word(input logic [NUM_IRQ-1:0] v,
                                           input logic [3:0] w);
    logic [PADW-1:0] p;
    p = PADW'(v);
    if (int'(w) < NW) return p[int'(w)*WORD_BITS +: WORD_BITS];
    return '0;
  endfunction

  always_comb begin
    case (rd_addr[7:4])
      RG_CTRL: rd_n = (rd_addr[3:0] == OFF_IDENT) ? IDENT : '0;
      RG_POL:  rd_n = get_word(pol,  rd_addr[3:0]);
      RG_TRIG: rd_n = get_word(trig, rd_addr[3:0]);
      RG_DUAL: rd_n = get_word(dual, rd_addr[3:0]);
      RG_PEND: rd_n = get_word(pend, rd_addr[3:0]);
      RG_MASK: rd_n = get_word(mask, rd_addr[3:0]);
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq_req <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_n;
      irq_req <= |(pend & mask);
    end
  end

  // R9
  req_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mask) == '0) |-> !irq_req);
endmodule

// File: tb/shirq_ctrl_test.sv
`timescale 1ns/1ps
module shirq_ctrl_test;
  localparam int N = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_in = '0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          rd_en = 1'b0;
  logic [7:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic          irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  shirq_ctrl #(.NUM_IRQ(N), .NUM_CPU(4)) uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_req(irq_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_pend(input int i, output logic v);
    logic [31:0] d;
    rd(8'(8'h40 + i / 32), d);
    v = d[i % 32];
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        v;
    logic [N-1:0] em;

    idle(3);
    rst = 1'b0;
    idle(2);

    // R1 identity word
    rd(8'h00, d); check("R1 ident", d, 32'h0004_0003);

    // R2 reset state
    rd(8'h10, d); check("R2 pol w0", d, 32'hFFFF_FFFF);
    rd(8'h11, d); check("R2 pol w1", d, 32'h0000_00FF);
    rd(8'h20, d); check("R2 trig w0", d, 0);
    rd(8'h21, d); check("R2 trig w1", d, 0);
    rd(8'h30, d); check("R2 dual w0", d, 0);
    rd(8'h31, d); check("R2 dual w1", d, 0);
    rd(8'h50, d); check("R2 mask w0", d, 0);
    rd(8'h51, d); check("R2 mask w1", d, 0);
    rd(8'h40, d); check("R2 pend w0", d, 0);
    check("R2 irq_req", 32'(irq_req), 0);

    // R11 padding and out-of-range words
    rd(8'h12, d); check("R11 pol w2", d, 0);
    wr(8'h21, 32'hFFFF_0F0F);
    rd(8'h21, d); check("R11 trig w1 pad", d, 32'h0000_000F);
    wr(8'h21, 32'h0);
    wr(8'h12, 32'h0);
    rd(8'h10, d); check("R11 pol w0 kept", d, 32'hFFFF_FFFF);
    rd(8'h11, d); check("R11 pol w1 kept", d, 32'h0000_00FF);
    wr(8'h30, 32'hA5A5_5A5A);
    rd(8'h30, d); check("R11 dual rw", d, 32'hA5A5_5A5A);
    wr(8'h30, 32'h0);

    // R8 enable set/clear by index
    em = '0;
    for (int i = 0; i < N; i++) begin
      wr(8'h01, 32'(i));
      em[i] = 1'b1;
      rd(8'h50, d); check("R8 set w0", d, em[31:0]);
      rd(8'h51, d); check("R8 set w1", d, {24'h0, em[39:32]});
    end
    wr(8'h02, 32'd40);
    wr(8'h02, 32'd255);
    rd(8'h51, d); check("R8 clr out of range", d, 32'h0000_00FF);
    for (int i = 0; i < N; i += 2) begin
      wr(8'h02, 32'(i));
      em[i] = 1'b0;
    end
    rd(8'h50, d); check("R8 clr even w0", d, em[31:0]);
    rd(8'h51, d); check("R8 clr even w1", d, {24'h0, em[39:32]});
    for (int i = 1; i < N; i += 2) wr(8'h02, 32'(i));
    wr(8'h01, 32'd40);
    wr(8'h01, 32'd200);
    rd(8'h50, d); check("R8 none w0", d, 0);
    rd(8'h51, d); check("R8 none w1", d, 0);

    // Sweep: every line through every sense setting
    for (int i = 0; i < N; i++) begin
      for (int m = 0; m < 6; m++) begin
        logic p, t, du, lat, x;
        logic [31:0] bv;
        string tag;
        int w;
        p   = (m == 0 || m == 2 || m == 4);
        t   = (m >= 2);
        du  = (m >= 4);
        w   = i / 32;
        bv  = 32'(1) << (i % 32);
        tag = t ? (du ? "R5" : "R4") : "R3";
        lat = 1'b0;
        x   = 1'b0;
        irq_in[i] = 1'b0;
        wr(8'(8'h10 + w), p ? 32'hFFFF_FFFF : ~bv);
        wr(8'(8'h30 + w), du ? bv : 32'h0);
        wr(8'(8'h20 + w), t ? bv : 32'h0);
        idle(4);
        rd_pend(i, v); check(tag, 32'(v), 32'(t ? lat : (p ? x : !x)));

        irq_in[i] = 1'b1; x = 1'b1;
        if (t && (du || p)) lat = 1'b1;
        idle(4);
        rd_pend(i, v); check(tag, 32'(v), 32'(t ? lat : (p ? x : !x)));

        wr(8'h01, 32'(i)); idle(2);
        check("R9 req enabled", 32'(irq_req), 32'(t ? lat : (p ? x : !x)));
        wr(8'h02, 32'(i)); idle(2);
        check("R9 req disabled", 32'(irq_req), 0);

        irq_in[i] = 1'b0; x = 1'b0;
        if (t && (du || !p)) lat = 1'b1;
        idle(4);
        rd_pend(i, v); check(tag, 32'(v), 32'(t ? lat : (p ? x : !x)));

        if (t) begin
          wr(8'h03, 32'(i)); idle(2);
          rd_pend(i, v); check("R6 clear", 32'(v), 0);
          wr(8'h03, 32'h8000_0000 | 32'(i)); idle(2);
          rd_pend(i, v); check("R7 raise", 32'(v), 1);
          wr(8'h03, 32'(i)); idle(2);
          rd_pend(i, v); check("R6 clear after raise", 32'(v), 0);
        end
        wr(8'(8'h20 + w), 32'h0);
        wr(8'(8'h30 + w), 32'h0);
        wr(8'(8'h10 + w), 32'hFFFF_FFFF);
      end
    end

    // R6 clearing one line leaves another captured
    wr(8'h20, 32'h0000_0008);
    wr(8'h21, 32'h0000_0008);
    irq_in[3] = 1'b1; irq_in[35] = 1'b1;
    idle(4);
    rd(8'h40, d); check("R6 both w0", d, 32'h0000_0008);
    rd(8'h41, d); check("R6 both w1", d, 32'h0000_0008);
    wr(8'h03, 32'd3); idle(2);
    rd(8'h40, d); check("R6 cleared w0", d, 0);
    rd(8'h41, d); check("R6 other kept w1", d, 32'h0000_0008);
    wr(8'h01, 32'd35); idle(2);
    check("R9 req one line", 32'(irq_req), 1);
    wr(8'h03, 32'd35); idle(2);
    check("R9 req after ack", 32'(irq_req), 0);
    wr(8'h02, 32'd35);
    irq_in[3] = 1'b0; irq_in[35] = 1'b0;
    wr(8'h20, 32'h0); wr(8'h21, 32'h0);
    idle(4);

    // R10 level-mode activity and raises leave no stale edge
    irq_in[5] = 1'b1; idle(4);
    irq_in[5] = 1'b0; idle(4);
    wr(8'h03, 32'h8000_0005); idle(2);
    rd(8'h40, d); check("R10 level raise ignored", d, 0);
    wr(8'h20, 32'h0000_0020); idle(2);
    rd(8'h40, d); check("R10 no stale edge", d, 0);
    wr(8'h20, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule